// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block is the target side of I/O read and I/O write transactions on a Low Pin Count bus. On each rising edge of the bus clock it samples the 4-bit multiplexed address/data lines and the active-low frame strobe. It recognises a start, decodes the transaction type, and assembles a 16-bit I/O address. It then compares that address against a parameterised table of register addresses. When an entry matches, the block takes ownership of the response phase. It drives the sync nibble, returns read data, drives the first target turnaround nibble, and controls a tri-state output enable.

Behind the bus, a narrow register-side port gives the index of the matched entry. It samples the read byte and issues a one-cycle write or read strobe. Nothing is committed until the transaction has fully completed. A transaction cut short by the frame strobe therefore leaves the registers behind the port untouched. The sync response always signals ready, so no wait states are ever inserted.

Top module: `lpc_io_target`

## Requirements
- R1: A transaction starts only when `lframe_ni` is low and `lad_i` is 4'b0000 at the same clock edge. The next nibble selects the transaction type: 4'b0000 is an I/O read and 4'b0010 is an I/O write. Any other type value ends the transaction with no drive, no busy and no strobe.
- R2: The four address nibbles arrive most significant first and form a 16-bit address. That address is compared with the NUM_REGS entries of REG_ADDRS, where entry i sits at bits 16*i+15 down to 16*i. The lowest matching index wins, and `reg_idx_o` holds that index for as long as `busy_o` is high.
- R3: An address that matches no entry causes no LAD drive, no busy and no strobe. The block then waits for the next start.
- R4: Cycles are numbered from the start nibble, which is cycle 0. In a write, `lad_i` carries data bits 3:0 in cycle 6 and bits 7:4 in cycle 7. `wr_strobe_o` is high for cycle 13 only, with `wr_data_o` and `reg_idx_o` valid in that cycle. `wr_strobe_o` and `rd_strobe_o` are never high together.
- R5: In a matched write, `lad_oe_o` is high only in cycle 10, where `lad_o` is 4'b0000, and in cycle 11, where `lad_o` is 4'b1111.
- R6: In a matched read, `lad_oe_o` is high only in cycles 8 to 11. `lad_o` carries 4'b0000 in cycle 8, read bits 3:0 in cycle 9, read bits 7:4 in cycle 10, and 4'b1111 in cycle 11. The enable is never high while `busy_o` is low.
- R7: In a read, `rd_data_i` is sampled on the clock edge that ends cycle 7. `rd_strobe_o` is high for cycle 13 only, with `reg_idx_o` valid in that cycle.
- R8: If `lframe_ni` is sampled low in cycle k of a transaction in progress, then from cycle k+1 `lad_oe_o` and `busy_o` are low and no strobe follows. If `lad_i` was 4'b0000 at that same edge, cycle k counts as cycle 0 of a new transaction.
- R9: While `rst_ni` is low, `lad_oe_o`, `busy_o` and both strobes are low, and a start on the bus is ignored.
- R10: `busy_o` is high in cycles 6 to 12 of a matched transaction and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Sampled address/data lines |
| lad_o | output | 4 | Nibble driven by the target |
| lad_oe_o | output | 1 | Output enable for lad_o |
| busy_o | output | 1 | Matched transaction in its data/response phase |
| reg_idx_o | output | IDX_W | Index of the matched address entry |
| rd_data_i | input | 8 | Read byte for the entry at reg_idx_o |
| wr_strobe_o | output | 1 | One-cycle write commit |
| wr_data_o | output | 8 | Byte to be written |
| rd_strobe_o | output | 1 | One-cycle read completion |

## Verification
Every result is tied to a fixed cycle counted from the start nibble. Busy rises in cycle 6. The sync nibble is due in cycle 8 for a read and in cycle 10 for a write. Read data follows in cycles 9 and 10, and the driven turnaround falls in cycle 11. Both strobes appear in cycle 13, one register after the final released turnaround. The bench drives one host nibble per falling edge. At each falling edge it first compares every output against the value expected for the current cycle number, so each check lands exactly where the pipeline places the result. Aborts are swept across cycles 1 to 12, and the bench then keeps checking the outputs for the rest of the window to confirm that no strobe arrives late.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [NIB_W-1:0] NIB_START = 4'h0;
  localparam logic [NIB_W-1:0] CT_IO_RD  = 4'h0;
  localparam logic [NIB_W-1:0] CT_IO_WR  = 4'h2;
  localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
  localparam logic [NIB_W-1:0] NIB_TAR   = 4'hF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADR1,
    ST_ADR2,
    ST_ADR3,
    ST_ADR4,
    ST_WD_LO,
    ST_WD_HI,
    ST_HTAR_DRV,
    ST_HTAR_Z,
    ST_SYNC,
    ST_RD_LO,
    ST_RD_HI,
    ST_TTAR_DRV,
    ST_TTAR_Z
  } bus_st_e;
endpackage

// File: rtl/lpc_io_addr_match.sv
module lpc_io_addr_match
  import lpc_io_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [NUM_REGS-1:0] eq;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign eq[g] = (addr_i == REG_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  // lowest index has priority
  always_comb begin
    hit_o = |eq;
    idx_o = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lpc_io_seq.sv
module lpc_io_seq
  import lpc_io_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [NIB_W-1:0]  lad_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_full_o,
  output bus_st_e           st_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_strobe_o,
  output logic              rd_strobe_o
);
  bus_st_e st_q, st_d;
  logic [ADDR_W-NIB_W-1:0] addr_q;
  logic is_wr_q;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W-1:0] wdata_q;
  logic wr_stb_q, rd_stb_q;

  assign addr_full_o = {addr_q, lad_i};

  always_comb begin
    st_d = st_q;
    if (!lframe_ni) begin
      // start or abort: re-evaluate start condition
      st_d = (lad_i == NIB_START) ? ST_TYPE : ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:     st_d = ST_IDLE;
        ST_TYPE:     st_d = (lad_i == CT_IO_RD || lad_i == CT_IO_WR) ? ST_ADR1 : ST_IDLE;
        ST_ADR1:     st_d = ST_ADR2;
        ST_ADR2:     st_d = ST_ADR3;
        ST_ADR3:     st_d = ST_ADR4;
        ST_ADR4:     st_d = !hit_i ? ST_IDLE : (is_wr_q ? ST_WD_LO : ST_HTAR_DRV);
        ST_WD_LO:    st_d = ST_WD_HI;
        ST_WD_HI:    st_d = ST_HTAR_DRV;
        ST_HTAR_DRV: st_d = ST_HTAR_Z;
        ST_HTAR_Z:   st_d = ST_SYNC;
        ST_SYNC:     st_d = is_wr_q ? ST_TTAR_DRV : ST_RD_LO;
        ST_RD_LO:    st_d = ST_RD_HI;
        ST_RD_HI:    st_d = ST_TTAR_DRV;
        ST_TTAR_DRV: st_d = ST_TTAR_Z;
        ST_TTAR_Z:   st_d = ST_IDLE;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      is_wr_q  <= 1'b0;
      idx_q    <= '0;
      wdata_q  <= '0;
      wr_stb_q <= 1'b0;
      rd_stb_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_TYPE) is_wr_q <= (lad_i == CT_IO_WR);
      if (st_q == ST_ADR1 || st_q == ST_ADR2 || st_q == ST_ADR3)
        addr_q <= {addr_q[ADDR_W-2*NIB_W-1:0], lad_i};
      if (st_q == ST_ADR4 && hit_i) idx_q <= idx_i;
      if (st_q == ST_WD_LO) wdata_q[NIB_W-1:0] <= lad_i;
      if (st_q == ST_WD_HI) wdata_q[DATA_W-1:NIB_W] <= lad_i;
      // commit only after the released target turnaround completes
      wr_stb_q <= (st_q == ST_TTAR_Z) && lframe_ni && is_wr_q;
      rd_stb_q <= (st_q == ST_TTAR_Z) && lframe_ni && !is_wr_q;
    end
  end

  assign st_o        = st_q;
  assign idx_o       = idx_q;
  assign wdata_o     = wdata_q;
  assign wr_strobe_o = wr_stb_q;
  assign rd_strobe_o = rd_stb_q;
endmodule

// File: rtl/lpc_io_lad_drv.sv
module lpc_io_lad_drv
  import lpc_io_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_st_e           st_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [NIB_W-1:0]  lad_o,
  output logic              lad_oe_o
);
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (st_i == ST_HTAR_Z) rdata_q <= rd_data_i;
  end

  always_comb begin
    lad_oe_o = 1'b1;
    lad_o    = NIB_TAR;
    unique case (st_i)
      ST_SYNC:     lad_o = NIB_READY;
      ST_RD_LO:    lad_o = rdata_q[NIB_W-1:0];
      ST_RD_HI:    lad_o = rdata_q[DATA_W-1:NIB_W];
      ST_TTAR_DRV: lad_o = NIB_TAR;
      default: begin
        lad_oe_o = 1'b0;
        lad_o    = '0;
      end
    endcase
  end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_io_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*16-1:0] REG_ADDRS = {16'hC001, 16'h3F08, 16'h0A24, 16'h0A20},
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lframe_ni,
  input  logic [3:0]       lad_i,
  output logic [3:0]       lad_o,
  output logic             lad_oe_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] reg_idx_o,
  input  logic [7:0]       rd_data_i,
  output logic             wr_strobe_o,
  output logic [7:0]       wr_data_o,
  output logic             rd_strobe_o
);
  logic [ADDR_W-1:0] addr_full;
  logic              hit;
  logic [IDX_W-1:0]  idx_cmp;
  bus_st_e           st;

  lpc_io_addr_match #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .REG_ADDRS(REG_ADDRS)
  ) u_match (
    .addr_i(addr_full),
    .hit_o (hit),
    .idx_o (idx_cmp)
  );

  lpc_io_seq #(
    .IDX_W(IDX_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lframe_ni  (lframe_ni),
    .lad_i      (lad_i),
    .hit_i      (hit),
    .idx_i      (idx_cmp),
    .addr_full_o(addr_full),
    .st_o       (st),
    .idx_o      (reg_idx_o),
    .wdata_o    (wr_data_o),
    .wr_strobe_o(wr_strobe_o),
    .rd_strobe_o(rd_strobe_o)
  );

  lpc_io_lad_drv u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (st),
    .rd_data_i(rd_data_i),
    .lad_o    (lad_o),
    .lad_oe_o (lad_oe_o)
  );

  always_comb begin
    unique case (st)
      ST_WD_LO, ST_WD_HI, ST_HTAR_DRV, ST_HTAR_Z, ST_SYNC,
      ST_RD_LO, ST_RD_HI, ST_TTAR_DRV, ST_TTAR_Z: busy_o = 1'b1;
      default: busy_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpc_io_checker.sv
module lpc_io_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lframe_ni,
  input logic [3:0]       lad_o,
  input logic             lad_oe_o,
  input logic             busy_o,
  input logic [IDX_W-1:0] reg_idx_o,
  input logic             wr_strobe_o,
  input logic             rd_strobe_o
);
  p_oe_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lad_oe_o |-> busy_o);

  // first driven nibble is always the ready sync (R5 as well)
  p_sync_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lad_oe_o) |-> lad_o == 4'h0);

  p_tar_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lad_oe_o) && $past(lframe_ni) |-> $past(lad_o) == 4'hF);

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_strobe_o && rd_strobe_o));

  p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !lframe_ni |=> !lad_oe_o && !busy_o && !wr_strobe_o && !rd_strobe_o);

  p_strobe_after_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_o || rd_strobe_o) |-> $past(busy_o) && $past(lframe_ni));

  p_idx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(reg_idx_o));
endmodule

bind lpc_io_target lpc_io_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lframe_ni  (lframe_ni),
  .lad_o      (lad_o),
  .lad_oe_o   (lad_oe_o),
  .busy_o     (busy_o),
  .reg_idx_o  (reg_idx_o),
  .wr_strobe_o(wr_strobe_o),
  .rd_strobe_o(rd_strobe_o)
);

// File: tb/tb_lpc_io_target.sv
module tb_lpc_io_target;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 4;
  localparam int IDX_W      = 2;
  localparam logic [NUM_REGS*16-1:0] ADDRS = {16'hC001, 16'h3F08, 16'h0A24, 16'h0A20};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lframe_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic lad_oe, busy, wr_stb, rd_stb;
  logic [IDX_W-1:0] reg_idx;
  logic [7:0] rd_data, wr_data;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rd_val(int i);
    return 8'(8'h3C + i * 81);
  endfunction

  assign rd_data = rd_val(int'(reg_idx));

  lpc_io_target #(.NUM_REGS(NUM_REGS), .REG_ADDRS(ADDRS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lframe_ni(lframe_n), .lad_i(lad_in),
    .lad_o(lad_out), .lad_oe_o(lad_oe), .busy_o(busy), .reg_idx_o(reg_idx),
    .rd_data_i(rd_data), .wr_strobe_o(wr_stb), .wr_data_o(wr_data),
    .rd_strobe_o(rd_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int find_idx(logic [15:0] a);
    for (int i = 0; i < NUM_REGS; i++)
      if (ADDRS[i*16 +: 16] == a) return i;
    return -1;
  endfunction

  // One transaction; cycle k is checked at the falling edge where nibble k is driven.
  task automatic run_txn(input logic [3:0] ctype, input logic [15:0] addr,
                         input logic [7:0] wd, input int abort_at,
                         input logic [3:0] abort_lad, input bit restarted);
    bit wr, valid, hit, live;
    int idx, last;
    logic [7:0] rv;
    logic exp_oe, exp_busy, exp_wr, exp_rd;
    logic [3:0] exp_lad;
    string tg;
    wr    = (ctype == 4'h2);
    valid = (ctype == 4'h0) || wr;
    idx   = valid ? find_idx(addr) : -1;
    hit   = (idx >= 0);
    rv    = hit ? rd_val(idx) : 8'h00;
    last  = (abort_at >= 0 && abort_lad == 4'h0) ? abort_at : 16;
    for (int k = (restarted ? 1 : 0); k <= last; k++) begin
      @(negedge clk);
      live = hit && !(abort_at >= 0 && k > abort_at);
      exp_oe = 1'b0; exp_lad = 4'h0;
      if (live && wr) begin
        if (k == 10) begin exp_oe = 1'b1; exp_lad = 4'h0; end
        if (k == 11) begin exp_oe = 1'b1; exp_lad = 4'hF; end
      end else if (live) begin
        if (k == 8)  begin exp_oe = 1'b1; exp_lad = 4'h0; end
        if (k == 9)  begin exp_oe = 1'b1; exp_lad = rv[3:0]; end
        if (k == 10) begin exp_oe = 1'b1; exp_lad = rv[7:4]; end
        if (k == 11) begin exp_oe = 1'b1; exp_lad = 4'hF; end
      end
      exp_busy = live && k >= 6 && k <= 12;
      exp_wr   = live && wr && k == 13;
      exp_rd   = live && !wr && k == 13;
      if (!valid) tg = "R1";
      else if (!hit) tg = "R3";
      else if (!live) tg = "R8";
      else tg = "";
      chk(lad_oe == exp_oe, tg != "" ? tg : (wr ? "R5" : "R6"), "lad_oe", int'(lad_oe), int'(exp_oe));
      if (exp_oe)
        chk(lad_out == exp_lad, wr ? "R5" : "R6", "lad_o", int'(lad_out), int'(exp_lad));
      chk(busy == exp_busy, tg != "" ? tg : "R10", "busy", int'(busy), int'(exp_busy));
      chk(wr_stb == exp_wr, tg != "" ? tg : "R4", "wr_strobe", int'(wr_stb), int'(exp_wr));
      chk(rd_stb == exp_rd, tg != "" ? tg : "R7", "rd_strobe", int'(rd_stb), int'(exp_rd));
      if (exp_busy || exp_wr || exp_rd)
        chk(int'(reg_idx) == idx, "R2", "reg_idx", int'(reg_idx), idx);
      if (exp_wr)
        chk(wr_data == wd, "R4", "wr_data", int'(wr_data), int'(wd));
      // drive nibble k
      if (k == abort_at) begin
        lframe_n = 1'b0; lad_in = abort_lad;
      end else if (k == 0) begin
        lframe_n = 1'b0; lad_in = 4'h0;
      end else begin
        lframe_n = 1'b1;
        if (k == 1) lad_in = ctype;
        else if (k >= 2 && k <= 5) lad_in = addr[15 - 4*(k-2) -: 4];
        else if (wr && k == 6) lad_in = wd[3:0];
        else if (wr && k == 7) lad_in = wd[7:4];
        else lad_in = 4'hF;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] dv [5];
    logic [15:0] a;
    // R9: reset state with a start presented on the bus
    repeat (2) @(negedge clk);
    lframe_n = 1'b0; lad_in = 4'h0;
    repeat (3) @(negedge clk);
    chk(!lad_oe && !busy && !wr_stb && !rd_stb, "R9", "outputs in reset",
        int'({lad_oe, busy, wr_stb, rd_stb}), 0);
    lframe_n = 1'b1; lad_in = 4'hF;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!lad_oe && !busy && !wr_stb && !rd_stb, "R9", "outputs after reset",
        int'({lad_oe, busy, wr_stb, rd_stb}), 0);

    // R4 R5 R6 R7 R10: every entry, several data patterns
    for (int i = 0; i < NUM_REGS; i++) begin
      dv[0] = 8'h00; dv[1] = 8'hFF; dv[2] = 8'hA5; dv[3] = 8'h5A; dv[4] = 8'(i * 17 + 1);
      for (int d = 0; d < 5; d++) begin
        run_txn(4'h2, ADDRS[i*16 +: 16], dv[d], -1, 4'hF, 1'b0);
        run_txn(4'h0, ADDRS[i*16 +: 16], 8'h00, -1, 4'hF, 1'b0);
      end
    end

    // R2 R3: every single-bit neighbour of every entry
    for (int i = 0; i < NUM_REGS; i++)
      for (int b = 0; b < 16; b++) begin
        a = ADDRS[i*16 +: 16] ^ (16'h1 << b);
        run_txn(4'h0, a, 8'h00, -1, 4'hF, 1'b0);
        run_txn(4'h2, a, 8'h69, -1, 4'hF, 1'b0);
      end

    // R1: unsupported type nibbles
    for (int t = 0; t < 16; t++)
      if (t != 0 && t != 2) run_txn(4'(t), ADDRS[15:0], 8'h11, -1, 4'hF, 1'b0);

    // R8: abort at every cycle, no restart
    for (int k = 1; k <= 12; k++) begin
      run_txn(4'h2, ADDRS[31:16], 8'hC3, k, 4'hF, 1'b0);
      run_txn(4'h0, ADDRS[47:32], 8'h00, k, 4'hF, 1'b0);
    end

    // R8: abort that doubles as a new start
    for (int j = 0; j < 3; j++) begin
      run_txn(4'h2, ADDRS[15:0], 8'h77, (j == 0) ? 3 : (j == 1) ? 8 : 12, 4'h0, 1'b0);
      run_txn(4'h0, ADDRS[63:48], 8'h00, -1, 4'hF, 1'b1);
      run_txn(4'h0, ADDRS[15:0], 8'h00, (j == 0) ? 6 : (j == 1) ? 9 : 11, 4'h0, 1'b0);
      run_txn(4'h2, ADDRS[31:16], 8'h3E, -1, 4'hF, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule